// File: doc/BRIEF.md
# Response ring write-pointer engine

This block holds the write-side state of a ring of response entries kept in system memory. A bus-master DMA path fills the ring. Software programs a 64-bit ring base address through two 32-bit registers. The lower register keeps only bits 31:7, so the ring always starts on a 128-byte boundary. Software reads a 16-bit pointer register to learn which entry was written last. Each entry is 8 bytes, and the ring holds 256 of them.

When a response is accepted, the engine computes the next index as the pointer plus one, wrapping modulo 256. It then issues a memory write request at base + index × 8, carrying the response data. The pointer takes the new index only on the clock edge where the memory side acknowledges. Software therefore never counts an entry as valid before its data is committed.

A run-enable input gates the engine. While the engine runs, or while a write is still pending, writes to the base registers and the pointer-clear bit are dropped, and a sticky error flag is raised.

Top module: `rsp_ring_wptr`

## Requirements
- R1: After reset, all three registers read 0, memReq is 0 and errFlag is 0.
- R2: Register select 0 is the lower base. A write stores regWdata[31:7], and bits 6:0 always read 0.
- R3: Register select 1 is the upper base, forming ring address bits 63:32. It is fully readable and writable.
- R4: Register select 2 is the pointer register, with the pointer in bits 7:0. Bits 15:8 and 31:16 read 0, and a write without bit 15 set leaves the pointer unchanged.
- R5: While stopped, writing select 2 with bit 15 set clears the pointer to 0. The next response then goes to index 1.
- R6: A response is accepted when rspValid and rspReady are both high at a clock edge. From the next cycle, memReq is 1, memAddr = {upper, lower[31:7], 7'b0} + ((pointer + 1) mod 256) × 8, and memData equals the accepted rspData.
- R7: While memReq is 1 and memAck is 0, memReq, memAddr and the pointer stay unchanged. On the edge with memAck high, the pointer becomes the new index and memReq drops.
- R8: The pointer wraps from 255 to 0, and entry 0 sits at the ring base itself.
- R9: rspReady is 1 only when runEn is 1 and no write is pending.
- R10: While runEn is 1 or a write is pending, writes to select 0, to select 1, or to select 2 with bit 15 set are ignored and set errFlag. errFlag stays 1 until reset.
- R11: Dropping runEn while a write is pending does not cancel that write. It completes on memAck and advances the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Engine run enable |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 lower base, 1 upper base, 2 pointer) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| rspValid | input | 1 | Response present |
| rspData | input | 64 | Response entry contents |
| rspReady | output | 1 | Response accepted at this edge if valid |
| memReq | output | 1 | Memory write request |
| memAddr | output | 64 | Byte address of the entry being written |
| memData | output | 64 | Entry data to write |
| memAck | input | 1 | Memory write committed |
| errFlag | output | 1 | Sticky flag for a configuration write made while running |

## Verification
The ring address is recomputed from the pointer and the base on every request. A pointer that is off by one, or a base that is corrupted, therefore shows up in memAddr in the first cycle of the next write. It also shows up at once in a read of select 2 or select 0. An early or late pointer update shows up as a pointer read that changes during an unacknowledged write, or that fails to change on the acknowledge edge. A run through more than 256 responses with varied acknowledge delays exposes wrap faults at the 255-to-0 step.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;

  localparam logic [1:0] SEL_BASE_LO = 2'd0;
  localparam logic [1:0] SEL_BASE_HI = 2'd1;
  localparam logic [1:0] SEL_WPTR    = 2'd2;
  localparam int         PTR_CLR_BIT = 15;

  typedef enum logic {ST_IDLE, ST_WRITE} ctlState_e;

  typedef struct packed {
    logic ldBaseLo;
    logic ldBaseHi;
    logic clrPtr;
    logic capture;
    logic advance;
  } dpStrobe_t;

endpackage

// File: rtl/rsp_ring_ctrl.sv
module rsp_ring_ctrl
  import rsp_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       rspValid,
  input  logic       memAck,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic       regClrBit,
  output logic       rspReady,
  output logic       memReq,
  output logic       errFlag,
  output dpStrobe_t  strobe
);

  ctlState_e state;
  logic busy;
  logic running;
  logic accept;
  logic cfgHit;

  assign busy     = (state == ST_WRITE);
  assign running  = runEn | busy;
  assign rspReady = runEn & ~busy;
  assign memReq   = busy;
  assign accept   = rspValid & rspReady;

  assign cfgHit = regWe & ((regAddr == SEL_BASE_LO) | (regAddr == SEL_BASE_HI) |
                           ((regAddr == SEL_WPTR) & regClrBit));

  always_comb begin
    strobe          = '0;
    strobe.ldBaseLo = regWe & (regAddr == SEL_BASE_LO) & ~running;
    strobe.ldBaseHi = regWe & (regAddr == SEL_BASE_HI) & ~running;
    strobe.clrPtr   = regWe & (regAddr == SEL_WPTR) & regClrBit & ~running;
    strobe.capture  = accept;
    strobe.advance  = busy & memAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:  if (accept) state <= ST_WRITE;
        ST_WRITE: if (memAck) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
      if (cfgHit && running) errFlag <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> !memReq); // R7
  AST_ACCEPT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady |=> memReq); // R6
  AST_NO_ACCEPT_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !(rspValid && rspReady)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R10

endmodule

// File: rtl/rsp_ring_dp.sv
module rsp_ring_dp
  import rsp_ring_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int PTR_W       = 8,
  parameter int ENTRY_SHIFT = 3,
  parameter int ALIGN_BITS  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic [DATA_W-1:0] rspData,
  output logic [31:0]       regRdata,
  output logic [63:0]       memAddr,
  output logic [DATA_W-1:0] memData
);

  localparam int ADDR_W = 64;
  localparam int OFS_W  = PTR_W + ENTRY_SHIFT;

  logic [31:ALIGN_BITS] baseLo;
  logic [31:0]          baseHi;
  logic [PTR_W-1:0]     wpReg;
  logic [DATA_W-1:0]    dataReg;
  logic [PTR_W-1:0]     nextIdx;
  logic [ADDR_W-1:0]    ringBase;
  logic [ADDR_W-1:0]    entryOfs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseLo  <= '0;
      baseHi  <= '0;
      wpReg   <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.ldBaseLo) baseLo <= regWdata[31:ALIGN_BITS];
      if (strobe.ldBaseHi) baseHi <= regWdata;
      if (strobe.clrPtr)       wpReg <= '0;
      else if (strobe.advance) wpReg <= wpReg + PTR_W'(1);
      if (strobe.capture) dataReg <= rspData;
    end
  end

  assign nextIdx  = wpReg + PTR_W'(1);
  assign ringBase = {baseHi, baseLo, {ALIGN_BITS{1'b0}}};
  assign entryOfs = {{(ADDR_W-OFS_W){1'b0}}, nextIdx, {ENTRY_SHIFT{1'b0}}};
  assign memAddr  = ringBase + entryOfs;
  assign memData  = dataReg;

  always_comb begin
    case (regAddr)
      SEL_BASE_LO: regRdata = {baseLo, {ALIGN_BITS{1'b0}}};
      SEL_BASE_HI: regRdata = baseHi;
      SEL_WPTR:    regRdata = {{(32-PTR_W){1'b0}}, wpReg};
      default:     regRdata = '0;
    endcase
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance && !strobe.clrPtr |=> $stable(wpReg)); // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.clrPtr |=> wpReg == $past(wpReg) + PTR_W'(1)); // R8
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldBaseLo && !strobe.ldBaseHi |=> $stable(ringBase)); // R10
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrPtr |=> wpReg == '0); // R5

endmodule

// File: rtl/rsp_ring_wptr.sv
module rsp_ring_wptr
  import rsp_ring_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int PTR_W       = 8,
  parameter int ENTRY_SHIFT = 3,
  parameter int ALIGN_BITS  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  output logic              rspReady,
  output logic              memReq,
  output logic [63:0]       memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memAck,
  output logic              errFlag
);

  dpStrobe_t strobe;

  rsp_ring_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .rspValid  (rspValid),
    .memAck    (memAck),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regClrBit (regWdata[PTR_CLR_BIT]),
    .rspReady  (rspReady),
    .memReq    (memReq),
    .errFlag   (errFlag),
    .strobe    (strobe)
  );

  rsp_ring_dp #(
    .DATA_W      (DATA_W),
    .PTR_W       (PTR_W),
    .ENTRY_SHIFT (ENTRY_SHIFT),
    .ALIGN_BITS  (ALIGN_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .rspData  (rspData),
    .regRdata (regRdata),
    .memAddr  (memAddr),
    .memData  (memData)
  );

endmodule

// File: tb/rsp_ring_wptr_tb.sv
module rsp_ring_wptr_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        rspValid = 1'b0;
  logic [63:0] rspData = '0;
  logic        rspReady;
  logic        memReq;
  logic [63:0] memAddr;
  logic [63:0] memData;
  logic        memAck = 1'b0;
  logic        errFlag;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;
  int expWp = 0;
  logic [31:0] expLo = '0;
  logic [31:0] expHi = '0;

  always #5 clk = ~clk;

  rsp_ring_wptr u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rspValid(rspValid), .rspData(rspData),
    .rspReady(rspReady), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memAck(memAck), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdChk(input string req, input logic [1:0] sel, input logic [31:0] exp);
    regAddr = sel;
    #1;
    chk(req, {32'b0, regRdata}, {32'b0, exp});
  endtask

  task automatic regWr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    regWe = 1'b1; regAddr = sel; regWdata = val;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  function automatic logic [63:0] entryAddr(input int idx);
    return {expHi, expLo[31:7], 7'b0} + 64'(idx * 8);
  endfunction

  // one response with ackDelay idle cycles; optionally drops runEn after accept
  task automatic doRsp(input logic [63:0] d, input int ackDelay, input bit dropRun);
    int nxt;
    nxt = (expWp + 1) % 256;
    @(negedge clk);
    rspValid = 1'b1; rspData = d;
    #1;
    chk("R9 ready while running idle", {63'b0, rspReady}, 64'd1);
    @(negedge clk);
    rspValid = 1'b0;
    if (dropRun) runEn = 1'b0;
    #1;
    chk("R6 memReq after accept", {63'b0, memReq}, 64'd1);
    chk("R6 memAddr", memAddr, entryAddr(nxt));
    chk("R6 memData", memData, d);
    for (int w = 0; w < ackDelay; w++) begin
      rdChk("R7 pointer held before ack", 2'd2, 32'(expWp));
      chk("R9 not ready while pending", {63'b0, rspReady}, 64'd0);
      @(negedge clk);
      #1;
      chk("R7 memReq held", {63'b0, memReq}, 64'd1);
      chk("R7 memAddr held", memAddr, entryAddr(nxt));
    end
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    expWp = nxt;
    #1;
    chk("R7 memReq released", {63'b0, memReq}, 64'd0);
    rdChk("R8 pointer after ack", 2'd2, 32'(expWp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdChk("R1 lower base reset", 2'd0, 32'h0);
    rdChk("R1 upper base reset", 2'd1, 32'h0);
    rdChk("R1 pointer reset", 2'd2, 32'h0);
    chk("R1 memReq reset", {63'b0, memReq}, 64'd0);
    chk("R1 errFlag reset", {63'b0, errFlag}, 64'd0);

    // R2 lower base alignment sweep over single bits
    for (int b = 0; b < 32; b++) begin
      regWr(2'd0, 32'(1) << b);
      rdChk("R2 lower base bit", 2'd0, (b < 7) ? 32'h0 : (32'(1) << b));
    end
    regWr(2'd0, 32'hFFFF_FFFF);
    rdChk("R2 lower base all ones", 2'd0, 32'hFFFF_FF80);
    // R3 upper base
    regWr(2'd1, 32'hA5A5_1234);
    rdChk("R3 upper base", 2'd1, 32'hA5A5_1234);
    regWr(2'd1, 32'h5A5A_EDCB);
    rdChk("R3 upper base", 2'd1, 32'h5A5A_EDCB);
    // R4 pointer field is read-only, reserved bits zero
    regWr(2'd2, 32'hFFFF_7FFF);
    rdChk("R4 pointer write ignored", 2'd2, 32'h0);

    expLo = 32'hFFFF_FFC0; expHi = 32'h0000_0001;
    regWr(2'd0, expLo);
    regWr(2'd1, expHi);
    runEn = 1'b1;
    for (int k = 0; k < 260; k++)
      doRsp({32'(k) * 32'h9E37_79B9, 32'(k)}, k % 3, 1'b0);
    rdChk("R8 pointer after wrap", 2'd2, 32'd4);
    chk("R10 no error after legal traffic", {63'b0, errFlag}, 64'd0);

    // R10 config writes while running
    regWr(2'd0, 32'h0000_1000);
    #1;
    chk("R10 errFlag set", {63'b0, errFlag}, 64'd1);
    rdChk("R10 lower base unchanged", 2'd0, 32'hFFFF_FF80);
    regWr(2'd1, 32'h0);
    rdChk("R10 upper base unchanged", 2'd1, expHi);
    regWr(2'd2, 32'h0000_8000);
    rdChk("R10 pointer clear ignored", 2'd2, 32'(expWp));

    // R11 drop runEn mid-write; pending write still blocks config
    fork
      doRsp(64'hDEAD_BEEF_0BAD_F00D, 3, 1'b1);
      begin
        repeat (3) @(negedge clk);
        regWe = 1'b1; regAddr = 2'd1; regWdata = 32'h7777_7777;
        @(negedge clk);
        regWe = 1'b0;
      end
    join
    rdChk("R11 write completed", 2'd2, 32'd5);
    rdChk("R10 upper base held while pending", 2'd1, expHi);
    chk("R10 errFlag sticky", {63'b0, errFlag}, 64'd1);

    // R9 stopped engine does not accept
    @(negedge clk);
    rspValid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R9 not ready when stopped", {63'b0, rspReady}, 64'd0);
      @(negedge clk);
      #1;
      chk("R9 no request when stopped", {63'b0, memReq}, 64'd0);
    end
    rspValid = 1'b0;

    // R5 pointer clear while stopped
    regWr(2'd2, 32'h0000_8000);
    rdChk("R5 pointer cleared, bit15 reads 0", 2'd2, 32'h0);
    expWp = 0;
    expLo = 32'h0000_0080; expHi = 32'h0000_0000;
    regWr(2'd0, expLo);
    regWr(2'd1, expHi);
    runEn = 1'b1;
    doRsp(64'h0123_4567_89AB_CDEF, 0, 1'b0);
    rdChk("R5 first entry index 1", 2'd2, 32'd1);
    chk("R10 errFlag still sticky", {63'b0, errFlag}, 64'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule